// File: doc/BRIEF.md
# LIN Slave Break Detector and Baud Recovery

This block watches the receive line of a LIN slave while the slave's byte receiver is still switched off. It looks for a Break, a low stretch on the line far longer than any data byte can produce, and reports it through a sticky flag and, when enabled, an interrupt line. Software acknowledges the flag. The block then waits for the delimiter, times the Sync byte (0x55) that follows, and derives a fresh baud divisor from it.

If the measured Sync timing falls within the tolerance window around the current bit time, the divisor is loaded into the receiver's baud generator with a one-cycle load strobe. The receiver is then enabled so that the header's remaining bytes and the response are received. If the timing is outside the window, a sync-error flag is raised, the divisor is kept, and the receiver stays off until the next Break. A Break seen while the receiver is on drops the receive enable and restarts the sequence.

Top module: `lin_autobaud`

## Requirements
- R1: After reset, brkFlag, brkIrq, syncErr, rxEnable and baudLoad are 0, and baudDiv equals the DIV_INIT parameter.
- R2: One bit time is baudDiv+1 clock cycles. A low run on rxLine of at least 11 bit times sets brkFlag. A low run shorter than 11 bit times leaves it clear. The line passes through a two-flop synchronizer first.
- R3: brkIrq is high exactly while brkFlag and brkIrqEn are both high.
- R4: brkFlag stays set until a brkClr pulse. While brkFlag is set, no Sync timing is taken: baudDiv, rxEnable and baudLoad do not change.
- R5: The span is the number of clock cycles from the Sync start-bit falling edge to the fourth falling edge after it. This covers 8 bit times. The new divisor is floor((span+4)/8) - 1.
- R6: For an accepted span, baudDiv takes the new divisor, baudLoad pulses high for exactly one cycle in that same cycle, and rxEnable goes high.
- R7: With nominal N = 8*(baudDiv+1), a span is rejected when span*50 < 43*N or span*50 > 57*N. A rejected span sets syncErr, leaves baudDiv unchanged and keeps rxEnable low.
- R8: syncErr stays set until an errClr pulse clears it.
- R9: A Break detected while rxEnable is high clears rxEnable. A data byte of all zeros (9 low bit times) is not taken as a Break.
- R10: Break detection after a divisor update uses the newly loaded divisor for its 11-bit threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counted in its cycles |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Asynchronous LIN receive line, idle high |
| brkIrqEn | input | 1 | Break interrupt enable level |
| brkClr | input | 1 | One-cycle pulse clearing brkFlag |
| errClr | input | 1 | One-cycle pulse clearing syncErr |
| brkFlag | output | 1 | Sticky Break-detected flag |
| brkIrq | output | 1 | Break interrupt request |
| syncErr | output | 1 | Sticky flag for a Sync span out of tolerance |
| rxEnable | output | 1 | Enable for the downstream byte receiver |
| baudLoad | output | 1 | One-cycle strobe loading baudDiv into the baud generator |
| baudDiv | output | DIV_W | Current baud divisor (bit time minus one, in cycles) |

## Verification
If the low-run counter or the divisor register holds a wrong value, the Break flag rises early or late against the 11-bit threshold. That error shows within a single Break. A wrong edge count or span counter shows as a wrong divisor on the load strobe, or as a false sync error at the end of the same Sync byte, about 8 bit times after its start edge. A stuck control state shows as rxEnable failing to follow the next Break or Sync. A stale divisor reappears as a shifted threshold on the Break after it, so each checked header exposes faults from the header before it.

// File: rtl/lin_autobaud_pkg.sv
package lin_autobaud_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic brkCntEn;   // low-run counter active
    logic spanStart;  // Sync start edge seen: clear span and edge counters
    logic spanEn;     // timing the Sync byte
    logic divLoad;    // take the computed divisor
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic brkHit;     // low run reached the Break threshold this cycle
    logic fallEdge;   // synchronized falling edge
    logic lineHigh;   // synchronized line level is high
    logic spanOk;     // span complete, within tolerance
    logic spanBad;    // span complete out of tolerance, or counter saturated
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CLR,
    ST_WAIT_HIGH,
    ST_WAIT_START,
    ST_MEASURE,
    ST_RUN
  } linSt_t;

endpackage

// File: rtl/lin_autobaud_dp.sv
module lin_autobaud_dp
  import lin_autobaud_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int DIV_INIT = 15,
  parameter int CNT_W    = DIV_W + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat,
  output logic [DIV_W-1:0] curDiv
);

  localparam int              MUL_W      = CNT_W + 7;
  localparam int              SYNC_FALLS = 4;
  localparam int              EDGE_W     = $clog2(SYNC_FALLS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] DIV_LIM   = CNT_W'(1) << DIV_W;
  localparam logic [MUL_W-1:0] TOL_SCALE = MUL_W'(50);
  localparam logic [MUL_W-1:0] TOL_LO    = MUL_W'(43);
  localparam logic [MUL_W-1:0] TOL_HI    = MUL_W'(57);

  // input synchronizer and edge detect
  logic rxMeta, rxSync, rxPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  logic fallEdge;
  assign fallEdge = rxPrev & ~rxSync;

  // bit length and Break threshold from the current divisor
  logic [CNT_W-1:0] bitLen, brkLimit, nomSpan;
  assign bitLen   = CNT_W'(curDiv) + CNT_W'(1);
  assign brkLimit = (bitLen << 3) + (bitLen << 1) + bitLen;
  assign nomSpan  = bitLen << 3;

  // consecutive low-sample counter
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowCnt <= '0;
    else if (!ctrl.brkCntEn || rxSync) lowCnt <= '0;
    else if (lowCnt != CNT_MAX)        lowCnt <= lowCnt + CNT_W'(1);
  end

  logic brkHit;
  assign brkHit = ctrl.brkCntEn & ~rxSync & (lowCnt == brkLimit - CNT_W'(1));

  // Sync span timing
  logic [CNT_W-1:0]  spanCnt;
  logic [EDGE_W-1:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spanCnt <= '0;
      edgeCnt <= '0;
    end else if (ctrl.spanStart) begin
      spanCnt <= '0;
      edgeCnt <= '0;
    end else if (ctrl.spanEn) begin
      if (spanCnt != CNT_MAX) spanCnt <= spanCnt + CNT_W'(1);
      if (fallEdge)           edgeCnt <= edgeCnt + EDGE_W'(1);
    end
  end

  logic             spanDone, spanSat, inRange, divFits;
  logic [CNT_W-1:0] spanNow, roundDiv;
  logic [MUL_W-1:0] spanScaled, loBound, hiBound;
  logic [DIV_W-1:0] newDiv;

  assign spanNow    = spanCnt + CNT_W'(1);
  assign spanSat    = ctrl.spanEn & (spanCnt == CNT_MAX);
  assign spanDone   = ctrl.spanEn & fallEdge & (edgeCnt == EDGE_W'(SYNC_FALLS - 1));
  assign spanScaled = MUL_W'(spanNow) * TOL_SCALE;
  assign loBound    = MUL_W'(nomSpan) * TOL_LO;
  assign hiBound    = MUL_W'(nomSpan) * TOL_HI;
  assign inRange    = (spanScaled >= loBound) && (spanScaled <= hiBound);
  assign roundDiv   = (spanNow + CNT_W'(4)) >> 3;
  assign divFits    = (roundDiv != '0) && (roundDiv <= DIV_LIM);
  assign newDiv     = DIV_W'(roundDiv - CNT_W'(1));

  // divisor register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             curDiv <= DIV_W'(DIV_INIT);
    else if (ctrl.divLoad) curDiv <= newDiv;
  end

  assign stat.brkHit   = brkHit;
  assign stat.fallEdge = fallEdge;
  assign stat.lineHigh = rxSync;
  assign stat.spanOk   = spanDone & inRange & divFits & ~spanSat;
  assign stat.spanBad  = spanSat | (spanDone & ~(inRange & divFits));

endmodule

// File: rtl/lin_autobaud_ctrl.sv
module lin_autobaud_ctrl
  import lin_autobaud_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    brkIrqEn,
  input  logic    brkClr,
  input  logic    errClr,
  output dpCtrl_t ctrl,
  output logic    brkFlag,
  output logic    brkIrq,
  output logic    syncErr,
  output logic    rxEnable,
  output logic    baudLoad
);

  linSt_t st, stNxt;
  logic   setBrk, setErr;

  always_comb begin
    ctrl   = '0;
    stNxt  = st;
    setBrk = 1'b0;
    setErr = 1'b0;
    unique case (st)
      ST_IDLE, ST_RUN: begin
        ctrl.brkCntEn = 1'b1;
        if (stat.brkHit) begin
          setBrk = 1'b1;
          stNxt  = ST_WAIT_CLR;
        end
      end
      ST_WAIT_CLR: begin
        if (!brkFlag) stNxt = ST_WAIT_HIGH;
      end
      ST_WAIT_HIGH: begin
        if (stat.lineHigh) stNxt = ST_WAIT_START;
      end
      ST_WAIT_START: begin
        if (stat.fallEdge) begin
          ctrl.spanStart = 1'b1;
          stNxt          = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        ctrl.spanEn = 1'b1;
        if (stat.spanOk) begin
          ctrl.divLoad = 1'b1;
          stNxt        = ST_RUN;
        end else if (stat.spanBad) begin
          setErr = 1'b1;
          stNxt  = ST_IDLE;
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      brkFlag  <= 1'b0;
      syncErr  <= 1'b0;
      rxEnable <= 1'b0;
      baudLoad <= 1'b0;
    end else begin
      st       <= stNxt;
      rxEnable <= (stNxt == ST_RUN);
      baudLoad <= ctrl.divLoad;
      if (setBrk)      brkFlag <= 1'b1;
      else if (brkClr) brkFlag <= 1'b0;
      if (setErr)      syncErr <= 1'b1;
      else if (errClr) syncErr <= 1'b0;
    end
  end

  assign brkIrq = brkFlag & brkIrqEn;

endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud
  import lin_autobaud_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int DIV_INIT = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             brkIrqEn,
  input  logic             brkClr,
  input  logic             errClr,
  output logic             brkFlag,
  output logic             brkIrq,
  output logic             syncErr,
  output logic             rxEnable,
  output logic             baudLoad,
  output logic [DIV_W-1:0] baudDiv
);

  localparam int CNT_W = DIV_W + 5;

  dpCtrl_t ctrl;
  dpStat_t stat;

  lin_autobaud_dp #(
    .DIV_W   (DIV_W),
    .DIV_INIT(DIV_INIT),
    .CNT_W   (CNT_W)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .rxLine(rxLine),
    .ctrl  (ctrl),
    .stat  (stat),
    .curDiv(baudDiv)
  );

  lin_autobaud_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .brkIrqEn(brkIrqEn),
    .brkClr  (brkClr),
    .errClr  (errClr),
    .ctrl    (ctrl),
    .brkFlag (brkFlag),
    .brkIrq  (brkIrq),
    .syncErr (syncErr),
    .rxEnable(rxEnable),
    .baudLoad(baudLoad)
  );

endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxLine,
  input logic             brkIrqEn,
  input logic             brkClr,
  input logic             errClr,
  input logic             brkFlag,
  input logic             brkIrq,
  input logic             syncErr,
  input logic             rxEnable,
  input logic             baudLoad,
  input logic [DIV_W-1:0] baudDiv
);

  // R3: interrupt only with a pending Break
  p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    brkIrq |-> brkFlag);

  // R4: flag is sticky until cleared
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (brkFlag && !brkClr) |=> brkFlag);

  // R4: receiver stays off while a Break is pending
  p_rx_off_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    brkFlag |-> !rxEnable);

  // R6: load strobe lasts one cycle
  p_load_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    baudLoad |=> !baudLoad);

  // R6: a load comes with the receiver enabled
  p_load_enables_r6: assert property (@(posedge clk) disable iff (!rstN)
    baudLoad |-> rxEnable);

  // R7: divisor changes only together with the load strobe
  p_div_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !baudLoad |-> $stable(baudDiv));

  // R8: sync error is sticky until cleared
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr && !errClr) |=> syncErr);

endmodule

bind lin_autobaud lin_autobaud_chk #(.DIV_W(DIV_W)) chk_i (.*);

// File: tb/lin_autobaud_tb_top.sv
`timescale 1ns/1ps
module lin_autobaud_tb_top;

  localparam int DIV_W    = 12;
  localparam int DIV_INIT = 15;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rxLine = 1'b1;
  logic             brkIrqEn = 1'b0;
  logic             brkClr = 1'b0;
  logic             errClr = 1'b0;
  logic             brkFlag, brkIrq, syncErr, rxEnable, baudLoad;
  logic [DIV_W-1:0] baudDiv;

  int total = 0;
  int bad = 0;
  int loadSeen = 0;
  int expDiv = DIV_INIT;
  bit done = 0;

  always #2 clk = ~clk;

  lin_autobaud #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .brkIrqEn(brkIrqEn),
    .brkClr(brkClr), .errClr(errClr), .brkFlag(brkFlag), .brkIrq(brkIrq),
    .syncErr(syncErr), .rxEnable(rxEnable), .baudLoad(baudLoad), .baudDiv(baudDiv)
  );

  always @(negedge clk) if (rstN && baudLoad) loadSeen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBrkClr();
    brkClr = 1'b1; @(negedge clk); brkClr = 1'b0;
  endtask

  task automatic pulseErrClr();
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
  endtask

  function automatic int divOf(input int span);
    return (span + 4) / 8 - 1;
  endfunction

  function automatic bit spanGood(input int span, input int div);
    int nom = 8 * (div + 1);
    return (span * 50 >= 43 * nom) && (span * 50 <= 57 * nom);
  endfunction

  // Sync byte 0x55 with the first 8 bit cells summing to span
  task automatic sendSync(input int span);
    int base = span / 8;
    int rem  = span % 8;
    hold(1'b0, base + (rem > 0 ? 1 : 0));
    for (int k = 0; k < 8; k++) begin
      int len = (k + 1 < 8) ? base + ((k + 1) < rem ? 1 : 0) : base;
      hold(((8'h55 >> k) & 1) != 0, len);
    end
    hold(1'b1, base);
  endtask

  task automatic sendByte(input logic [7:0] b, input int bitLen);
    hold(1'b0, bitLen);
    for (int k = 0; k < 8; k++) hold(b[k], bitLen);
    hold(1'b1, bitLen);
  endtask

  // Break plus Sync, with all checks
  task automatic header(input int span, input bit ie, input bit wasRun);
    int bitLen = expDiv + 1;
    int ldBefore;
    int divBefore;
    brkIrqEn = ie;
    hold(1'b0, 12 * bitLen);
    check(brkFlag == 1'b1, "R2 break flag", brkFlag, 1);
    check(brkIrq == ie, "R3 irq follows enable", brkIrq, ie);
    if (wasRun) check(rxEnable == 1'b0, "R9 break drops rx", rxEnable, 0);
    pulseBrkClr();
    check(brkFlag == 1'b0, "R4 flag cleared", brkFlag, 0);
    check(brkIrq == 1'b0, "R3 irq low without flag", brkIrq, 0);
    hold(1'b0, bitLen);
    hold(1'b1, 2 * bitLen);
    ldBefore  = loadSeen;
    divBefore = expDiv;
    sendSync(span);
    hold(1'b1, 4 * bitLen);
    if (spanGood(span, divBefore)) begin
      expDiv = divOf(span);
      check(int'(baudDiv) == expDiv, "R5 new divisor", baudDiv, expDiv);
      check(rxEnable == 1'b1, "R6 rx enabled", rxEnable, 1);
      check(loadSeen == ldBefore + 1, "R6 one load pulse", loadSeen - ldBefore, 1);
      check(syncErr == 1'b0, "R6 no sync error", syncErr, 0);
    end else begin
      check(syncErr == 1'b1, "R7 sync error set", syncErr, 1);
      check(int'(baudDiv) == divBefore, "R7 divisor kept", baudDiv, divBefore);
      check(rxEnable == 1'b0, "R7 rx stays off", rxEnable, 0);
      check(loadSeen == ldBefore, "R7 no load", loadSeen - ldBefore, 0);
      hold(1'b1, 3);
      check(syncErr == 1'b1, "R8 error sticky", syncErr, 1);
      pulseErrClr();
      check(syncErr == 1'b0, "R8 error cleared", syncErr, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bitLen, nom, lo, hi, ld0, div0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(brkFlag == 0 && brkIrq == 0 && syncErr == 0, "R1 flags reset", {brkFlag, brkIrq, syncErr}, 0);
    check(rxEnable == 0 && baudLoad == 0, "R1 rx and load reset", {rxEnable, baudLoad}, 0);
    check(int'(baudDiv) == DIV_INIT, "R1 divisor reset", baudDiv, DIV_INIT);

    // R2 threshold: just short of 11 bits, then past it
    bitLen = expDiv + 1;
    hold(1'b0, 11 * bitLen - 2);
    hold(1'b1, 8);
    check(brkFlag == 1'b0, "R2 short low ignored", brkFlag, 0);
    hold(1'b0, 11 * bitLen + 6);
    check(brkFlag == 1'b1, "R2 threshold reached", brkFlag, 1);
    pulseBrkClr();
    hold(1'b1, 2 * bitLen);
    sendSync(8 * bitLen);
    hold(1'b1, 4 * bitLen);
    check(int'(baudDiv) == DIV_INIT && rxEnable == 1, "R5 exact span keeps divisor", baudDiv, DIV_INIT);

    // R9 all-zero data byte while receiving
    sendByte(8'h00, bitLen);
    hold(1'b1, 6);
    check(brkFlag == 1'b0, "R9 zero byte not a break", brkFlag, 0);
    check(rxEnable == 1'b1, "R9 rx still on", rxEnable, 1);

    // R7 tolerance edges around current nominal
    nom = 8 * (expDiv + 1);
    lo = (43 * nom + 49) / 50;
    hi = (57 * nom) / 50;
    header(lo - 1, 1'b1, 1'b1);
    header(hi + 1, 1'b0, 1'b0);
    header(hi, 1'b1, 1'b0);
    header(lo + 3, 1'b0, 1'b1);

    // R4 Sync ignored while flag pending
    bitLen = expDiv + 1;
    ld0 = loadSeen;
    div0 = expDiv;
    hold(1'b0, 12 * bitLen);
    hold(1'b1, 2 * bitLen);
    sendSync(8 * bitLen + 4);
    hold(1'b1, 4 * bitLen);
    check(brkFlag == 1'b1, "R4 flag still set", brkFlag, 1);
    check(loadSeen == ld0 && int'(baudDiv) == div0, "R4 no timing while flagged", baudDiv, div0);
    check(rxEnable == 1'b0, "R4 rx off while flagged", rxEnable, 0);
    pulseBrkClr();
    hold(1'b1, 2 * bitLen);
    sendSync(8 * bitLen + 4);
    hold(1'b1, 4 * bitLen);
    expDiv = divOf(8 * bitLen + 4);
    check(int'(baudDiv) == expDiv, "R5 rounding up after clear", baudDiv, expDiv);

    // R10 random headers, threshold follows the new divisor
    for (int i = 0; i < 30; i++) begin
      int pct;
      int span;
      bit ie;
      bitLen = expDiv + 1;
      if (bitLen > 30)      pct = 80 + int'($urandom % 21);
      else if (bitLen < 10) pct = 100 + int'($urandom % 21);
      else                  pct = 80 + int'($urandom % 41);
      span = (8 * bitLen * pct) / 100 + int'($urandom % 8);
      ie = bit'($urandom % 2);
      if (rxEnable) begin
        hold(1'b0, 11 * bitLen - 3);
        hold(1'b1, 6);
        check(brkFlag == 1'b0 && rxEnable == 1'b1, "R10 threshold uses new divisor", brkFlag, 0);
      end
      header(span, ie, rxEnable);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule